// File: doc/BRIEF.md
# Strap-Latched Configuration Selector

This block decides, once per reset, who owns the configuration of a programmable clock device. One clock cycle after reset is released it captures a mode strap. A strap of 1 turns two shared pins into a two-bit bank index. A strap of 0 hands the pins to the serial host bus, and bank 0 stands for the host default. A stored lock bit that is set forces host ownership even when the strap asks for pin mode. The block issues a one-cycle load strobe with the chosen bank index so that downstream logic can fetch that configuration.

In pin mode the block keeps watching the select pins. Each pin passes through a synchronizer and a stability filter. A change is acted on only after a start-up window measured in millisecond ticks. A change of one bit loads the new bank and starts a settle period, and any pin activity during that period is absorbed. A change of both bits at once is a protocol violation. It raises a sticky error, and the bank in use is kept.

Top module: `cfgsel_top`

## Requirements
- R1: The strap is captured on the first clock edge after reset release and is held until the next reset. Later strap levels have no effect on `host_mode_o`.
- R2: With strap 1 and lock 0, the block is in pin mode. `host_mode_o` is 0 and `bank_o` is set to `{sel_i[1], sel_i[0]}` as captured at reset release (00 gives bank 0, 01 bank 1, 10 bank 2, 11 bank 3).
- R3: With strap 0, `host_mode_o` is 1, `bank_o` is 0 and the select pins never change the bank.
- R4: With strap 1 and lock 1, `host_mode_o` is 1, `bank_o` is 0 and the select pins never change the bank.
- R5: `load_o` is high for exactly one cycle once after reset release, and once for each accepted bank change. It is high at no other time.
- R6: Until STARTUP_TICKS millisecond ticks have been counted since reset release, pin changes are ignored. This includes a new value that is still present when the window closes.
- R7: In pin mode after the start-up window, a change of one select bit that holds stable for STABLE_CYC cycles sets `bank_o` to the new pin value and pulses `load_o`.
- R8: After an accepted change the block stays busy until SETTLE_TICKS ticks have been counted. Pin changes made while it is busy are ignored, even after the busy time ends.
- R9: A filtered change of both select bits at once sets `err_o` and leaves `bank_o` unchanged with no load strobe. `err_o` clears only on reset.
- R10: While reset is asserted, `bank_o` = 0, `load_o` = 0, `host_mode_o` = 0 and `err_o` = 0.
- R11: A select-pin pulse that lasts fewer than STABLE_CYC cycles does not change the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| strap_i | input | 1 | Mode strap (1 = pin select, 0 = host bus) |
| sel_i | input | 2 | Shared select pins, asynchronous |
| lock_i | input | 1 | Stored lock bit forcing host ownership |
| bank_o | output | 2 | Selected configuration bank |
| load_o | output | 1 | One-cycle load request |
| host_mode_o | output | 1 | Host bus owns configuration |
| err_o | output | 1 | Sticky simultaneous-change error |

## Verification
The hardest case to reach is a pin change made while the block is busy, either in the start-up window or in the settle window, that is then left in place after the window closes. A design that compares against the last accepted bank would accept it late. The stimulus changes a pin without giving ticks, waits well past the filter latency, and then supplies the ticks that close the window. It then confirms that neither the bank nor the load count moves. After that, a one-bit change away from the absorbed value proves that the block is responsive again.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_STARTUP,
        ST_IDLE,
        ST_SETTLE,
        ST_HOST
    } cfg_state_t;

    typedef struct packed {
        cfg_state_t       st;
        logic             host;
        logic [SEL_W-1:0] bank;
        logic [SEL_W-1:0] pins_ref;
        logic             load;
        logic             err;
    } cfg_ctl_t;
endpackage

// File: rtl/cfgsel_sync.sv
module cfgsel_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= '0;
                else         chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgsel_filter.sv
module cfgsel_filter #(
    parameter int WIDTH      = 2,
    parameter int STABLE_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] value_o,
    output logic             valid_o
);
    localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
    localparam logic [CW-1:0] CMAX = CW'(STABLE_CYC - 1);

    logic [WIDTH-1:0] cand_d, cand_q;
    logic [CW-1:0]    cnt_d, cnt_q;

    always_comb begin
        cand_d = cand_q;
        cnt_d  = cnt_q;
        if (in_i != cand_q) begin
            cand_d = in_i;
            cnt_d  = '0;
        end else if (cnt_q != CMAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cand_q <= '0;
            cnt_q  <= '0;
        end else begin
            cand_q <= cand_d;
            cnt_q  <= cnt_d;
        end
    end

    assign value_o = cand_q;
    assign valid_o = (cnt_q == CMAX);

    // R11: a candidate that moved last cycle is never reported as valid yet
    p_fresh_invalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_i != cand_q) |=> (STABLE_CYC == 1) || !valid_o);
endmodule

// File: rtl/cfgsel_tick_timer.sv
module cfgsel_tick_timer #(
    parameter int LIMIT = 11
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       clear_i,
    input  logic                       tick_i,
    output logic [$clog2(LIMIT+1)-1:0] count_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] TMAX = TW'(LIMIT);

    logic [TW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear_i)                    count_d = '0;
        else if (tick_i && count_q != TMAX) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end

    assign count_o = count_q;

    // R6/R8: the tick count saturates instead of wrapping
    p_saturate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_q == TMAX && !clear_i) |=> count_q == TMAX);
endmodule

// File: rtl/cfgsel_top.sv
module cfgsel_top
    import cfgsel_pkg::*;
#(
    parameter int STABLE_CYC    = 4,
    parameter int STARTUP_TICKS = 11,
    parameter int SETTLE_TICKS  = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ms_tick_i,
    input  logic             strap_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             lock_i,
    output logic [SEL_W-1:0] bank_o,
    output logic             load_o,
    output logic             host_mode_o,
    output logic             err_o
);
    localparam int TLIM = (STARTUP_TICKS > SETTLE_TICKS) ? STARTUP_TICKS : SETTLE_TICKS;
    localparam int TW   = $clog2(TLIM + 1);
    localparam logic [TW-1:0] T_START  = TW'(STARTUP_TICKS);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_TICKS);

    cfg_ctl_t         ctl_d, ctl_q;
    logic [SEL_W-1:0] sel_sync;
    logic [SEL_W-1:0] filt_val;
    logic             filt_ok;
    logic [TW-1:0]    tcount;
    logic             tclear;
    logic [SEL_W-1:0] diff;

    cfgsel_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(sel_i),
        .sync_o (sel_sync)
    );

    cfgsel_filter #(.WIDTH(SEL_W), .STABLE_CYC(STABLE_CYC)) u_filt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_i   (sel_sync),
        .value_o(filt_val),
        .valid_o(filt_ok)
    );

    cfgsel_tick_timer #(.LIMIT(TLIM)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(tclear),
        .tick_i (ms_tick_i),
        .count_o(tcount)
    );

    assign diff = filt_val ^ ctl_q.pins_ref;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.load = 1'b0;
        tclear     = 1'b0;
        unique case (ctl_q.st)
            ST_INIT: begin
                tclear         = 1'b1;
                ctl_d.host     = !strap_i || lock_i;
                ctl_d.bank     = (!strap_i || lock_i) ? '0 : sel_i;
                ctl_d.pins_ref = sel_i;
                ctl_d.load     = 1'b1;
                ctl_d.st       = (!strap_i || lock_i) ? ST_HOST : ST_STARTUP;
            end
            ST_STARTUP: begin
                if (filt_ok) ctl_d.pins_ref = filt_val;
                if (tcount >= T_START) ctl_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (filt_ok && diff != '0) begin
                    ctl_d.pins_ref = filt_val;
                    if ($countones(diff) > 1) begin
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.bank = filt_val;
                        ctl_d.load = 1'b1;
                        ctl_d.st   = ST_SETTLE;
                        tclear     = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (filt_ok) ctl_d.pins_ref = filt_val;
                if (tcount >= T_SETTLE) ctl_d.st = ST_IDLE;
            end
            ST_HOST: begin
                ctl_d.bank = '0;
            end
            default: ctl_d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.st       <= ST_INIT;
            ctl_q.host     <= 1'b0;
            ctl_q.bank     <= '0;
            ctl_q.pins_ref <= '0;
            ctl_q.load     <= 1'b0;
            ctl_q.err      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bank_o      = ctl_q.bank;
    assign load_o      = ctl_q.load;
    assign host_mode_o = ctl_q.host;
    assign err_o       = ctl_q.err;

    // R5: the load request never lasts longer than one cycle
    p_load_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> !load_o);

    // R7: the bank only ever moves together with a load request
    p_bank_with_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(bank_o) |-> load_o);

    // R1: ownership is frozen once the strap has been captured
    p_owner_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st != ST_INIT) |=> $stable(host_mode_o));

    // R3: host ownership always presents bank zero
    p_host_bank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_mode_o |-> bank_o == '0);

    // R9: the error flag holds once set
    p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    // R9: raising the error leaves the bank alone and requests no load
    p_err_keeps_bank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> ($stable(bank_o) && !load_o));

    // R8: a busy block stays busy while the settle count is short
    p_settle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_SETTLE && tcount < T_SETTLE) |=> $stable(bank_o));
endmodule

// File: tb/cfgsel_top_tb_top.sv
module cfgsel_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       strap = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       lock = 1'b0;
    logic [1:0] bank;
    logic       load;
    logic       host;
    logic       err;

    int n_checks = 0;
    int n_fail   = 0;
    int n_load   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cfgsel_top dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ms_tick_i  (tick),
        .strap_i    (strap),
        .sel_i      (sel),
        .lock_i     (lock),
        .bank_o     (bank),
        .load_o     (load),
        .host_mode_o(host),
        .err_o      (err)
    );

    always @(negedge clk) if (load) n_load++;

    // fields: {new sel[1:0], expected bank[1:0], load increment, expected err}
    localparam logic [5:0] VEC [5] = '{
        {2'b01, 2'd1, 1'b1, 1'b0},
        {2'b11, 2'd3, 1'b1, 1'b0},
        {2'b10, 2'd2, 1'b1, 1'b0},
        {2'b01, 2'd2, 1'b0, 1'b1},
        {2'b00, 2'd0, 1'b1, 1'b1}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            cyc(3);
        end
    endtask

    task automatic do_reset(input logic s, input logic [1:0] p, input logic lk);
        rst_n = 1'b0;
        strap = s;
        sel   = p;
        lock  = lk;
        cyc(3);
        check("R10 bank in reset", bank, 0);
        check("R10 load in reset", load, 0);
        check("R10 host in reset", host, 0);
        check("R10 err in reset",  err, 0);
        n_load = 0;
        rst_n  = 1'b1;
        cyc(4);
    endtask

    initial begin
        int base;
        // R2/R5/R6/R7/R1: pin mode start with bank 2
        do_reset(1'b1, 2'b10, 1'b0);
        check("R2 bank at release", bank, 2);
        check("R2 host flag", host, 0);
        check("R5 one load at release", n_load, 1);
        sel = 2'b11;
        cyc(20);
        check("R6 change during start-up", bank, 2);
        ticks(12);
        cyc(20);
        check("R6 held value after window", bank, 2);
        check("R6 no load", n_load, 1);
        strap = 1'b0;
        sel = 2'b01;
        cyc(20);
        check("R7 one-bit change accepted", bank, 1);
        check("R5 load per change", n_load, 2);
        check("R1 strap change ignored", host, 0);

        // vector table from bank 0 in pin mode
        do_reset(1'b1, 2'b00, 1'b0);
        ticks(12);
        for (int v = 0; v < 5; v++) begin
            base = n_load;
            sel = VEC[v][5:4];
            cyc(20);
            check("R7/R9 vector bank", bank, int'(VEC[v][3:2]));
            check("R5 vector load count", n_load - base, int'(VEC[v][1]));
            check("R9 vector err", err, int'(VEC[v][0]));
            ticks(3);
        end

        // R11: short glitch
        base = n_load;
        sel = 2'b01;
        cyc(2);
        sel = 2'b00;
        cyc(20);
        check("R11 glitch bank", bank, 0);
        check("R11 glitch load", n_load - base, 0);

        // R8: changes during settle are absorbed
        sel = 2'b10;
        cyc(20);
        check("R7 accept before settle", bank, 2);
        base = n_load;
        sel = 2'b11;
        cyc(20);
        check("R8 change while busy", bank, 2);
        ticks(3);
        cyc(20);
        check("R8 absorbed after busy", bank, 2);
        check("R8 no load", n_load - base, 0);
        sel = 2'b01;
        cyc(20);
        check("R8 responsive again", bank, 1);

        // R9: error clears only through reset (checked in do_reset)
        check("R9 err still set", err, 1);

        // R3: host bus mode
        do_reset(1'b0, 2'b11, 1'b0);
        check("R3 host flag", host, 1);
        check("R3 bank zero", bank, 0);
        check("R5 load in host mode", n_load, 1);
        ticks(12);
        sel = 2'b10;
        cyc(20);
        check("R3 pins ignored", bank, 0);
        check("R3 no load", n_load, 1);

        // R4: lock forces host ownership
        do_reset(1'b1, 2'b11, 1'b1);
        check("R4 host flag", host, 1);
        check("R4 bank zero", bank, 0);
        ticks(12);
        sel = 2'b10;
        cyc(20);
        check("R4 pins ignored", bank, 0);
        check("R4 no load", n_load, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule